// File: doc/BRIEF.md
# Seven-to-one pixel serializer

This block turns parallel pixel words into serial lane bits for a display link. A fast bit clock runs at seven times the pixel rate. On every rising edge of that clock each data lane sends one bit, at single data rate. Together with the lanes the block drives a forwarded pixel clock. That clock is a fixed seven-step waveform taken from a parameter, so it has no 50 % duty cycle.

A modulo-seven phase counter paces all lanes, the forwarded clock and two phase strobes. Pixel-rate logic elsewhere, such as a sync generator, uses these strobes. It starts its update on the start strobe and its result is taken on the capture strobe. The result therefore has several fast cycles to settle, so that logic does not have to close timing at the full bit rate. A typical pairing is a bit clock near 360 MHz with a pixel rate near 51.4 MHz.

New words are offered with a valid flag. They are taken only on the edge at which the block signals that it is ready, which is once per pixel period.

Top module: `pix_serializer7`

## Requirements
- R1: The `phase` output steps 0,1,2,3,4,5,6 and then returns to 0, one step per clock. Each pixel period is exactly seven clocks.
- R2: `load_ready` is high only while `phase` is 6. When `load_valid` is high on that clock edge, the lane words are captured and `phase` becomes 0.
- R3: A captured word for a lane is sent most significant bit first. While `phase` is k, lane bit equals word bit 6-k. Lane g takes its word from `lane_words[7*g+6 : 7*g]`.
- R4: All lanes shift in lockstep from the same phase counter. Each lane sends its own word during the same seven clocks.
- R5: `fwd_clk` follows `FCLK_PATTERN`, bit p being the level during phase p. The default 7'b1100011 gives high, high, low, low, low, high, high over phases 0 to 6.
- R6: `start_stb` is high for exactly the one clock in which `phase` equals `START_PHASE` (default 3).
- R7: `capture_stb` is high for exactly the one clock in which `phase` equals `CAPTURE_PHASE` (default 1).
- R8: If `load_valid` is low on the phase-6 edge, every lane sends seven zero bits in the following period.
- R9: `load_valid` and `lane_words` have no effect on any output unless `phase` is 6 at that edge.
- R10: A synchronous `rst` sets `phase` to 0 and every lane bit to 0. It sets `fwd_clk` to pattern bit 0 (high by default) and each strobe to the value its phase-0 test gives (both low by default). Reset wins over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Offered lane words are valid |
| lane_words | input | 7*LANES | One 7-bit word per lane, lane 0 lowest |
| load_ready | output | 1 | Words are taken on this edge if valid |
| lane_bits | output | LANES | Serial bit of each lane |
| fwd_clk | output | 1 | Forwarded pixel clock waveform |
| phase | output | 3 | Current phase, 0 to 6 |
| start_stb | output | 1 | One-clock pulse at the start phase |
| capture_stb | output | 1 | One-clock pulse at the capture phase |

## Verification
A reset in the middle of a pixel period is the hardest case to reach. It must throw away a half-sent word and restart the waveform and the strobes from phase 0. The stimulus waits on the reference model's phase and raises reset at phase 4. It also raises reset on a phase-6 edge on which valid words are offered. Both lane words and `load_valid` are also changed at random on every non-ready clock, which shows that only the phase-6 edge samples them. Whole periods with valid held low then confirm that the lanes go to zeros.

// File: rtl/pser_pkg.sv
package pser_pkg;

   localparam int unsigned PIX_PHASES_DEFAULT = 7;

   // level of the forwarded clock in phase p is bit p
   localparam logic [PIX_PHASES_DEFAULT-1:0] FCLK_PATTERN_DEFAULT = 7'b1100011;

   function automatic int unsigned phase_bits(input int unsigned phases);
      return (phases < 2) ? 1 : $clog2(phases);
   endfunction

endpackage

// File: rtl/pser_phase_ctr.sv
module pser_phase_ctr #(
   parameter int unsigned PHASES = 7,
   parameter int unsigned PW     = 3
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] ph,
   output logic [PW-1:0] ph_next,
   output logic          wrap
);

   localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

   always_comb begin
      wrap    = (ph == LAST);
      ph_next = wrap ? '0 : ph + PW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) ph <= '0;
      else     ph <= ph_next;
   end

   // R1: counter leaves the last phase for zero
   a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (ph == LAST) |=> (ph == '0));

   // R1: every other phase advances by one
   a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
      (ph != LAST) |=> (ph == $past(ph) + PW'(1)));

   // R1: counter never leaves the legal range
   a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
      ph <= LAST);

endmodule

// File: rtl/pser_lane_shift.sv
module pser_lane_shift #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_word,
   output logic             ser_o
);

   logic [WIDTH-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst)          sr <= '0;
      else if (load_en) sr <= load_word;
      else              sr <= {sr[WIDTH-2:0], 1'b0};
   end

   assign ser_o = sr[WIDTH-1];

   // R2: the word offered on the load edge is what the register holds next
   a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (sr == $past(load_word)));

   // R3: between loads the register moves one place toward the MSB
   a_r3_shift_msb_first: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> (sr == {$past(sr[WIDTH-2:0]), 1'b0}));

endmodule

// File: rtl/pser_fclk_gen.sv
module pser_fclk_gen #(
   parameter int unsigned     PHASES  = 7,
   parameter int unsigned     PW      = 3,
   parameter logic [PHASES-1:0] PATTERN = 7'b1100011
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] ph,
   input  logic [PW-1:0] ph_next,
   output logic          fclk
);

   // registered from the next phase so the pin is driven straight from a flop
   always_ff @(posedge clk) begin
      if (rst) fclk <= PATTERN[0];
      else     fclk <= PATTERN[ph_next];
   end

   // R5: waveform level matches the pattern bit of the live phase
   a_r5_fclk_follows_phase: assert property (@(posedge clk) disable iff (rst)
      fclk == PATTERN[ph]);

endmodule

// File: rtl/pser_strobe.sv
module pser_strobe #(
   parameter int unsigned PW     = 3,
   parameter int unsigned TARGET = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] ph,
   input  logic [PW-1:0] ph_next,
   output logic          stb
);

   localparam logic [PW-1:0] TGT = PW'(TARGET);

   always_ff @(posedge clk) begin
      if (rst) stb <= (TARGET == 0);
      else     stb <= (ph_next == TGT);
   end

   // R6 R7: strobe only in its target phase
   a_r6_r7_strobe_only_at_target: assert property (@(posedge clk) disable iff (rst)
      stb |-> (ph == TGT));

   // R6 R7: target phase always carries the strobe
   a_r6_r7_target_has_strobe: assert property (@(posedge clk) disable iff (rst)
      (ph == TGT) |-> stb);

endmodule

// File: rtl/pix_serializer7.sv
module pix_serializer7
   import pser_pkg::*;
#(
   parameter int unsigned       LANES         = 4,
   parameter int unsigned       PHASES        = PIX_PHASES_DEFAULT,
   parameter logic [PHASES-1:0] FCLK_PATTERN  = FCLK_PATTERN_DEFAULT,
   parameter int unsigned       START_PHASE   = 3,
   parameter int unsigned       CAPTURE_PHASE = 1,
   localparam int unsigned      PW            = phase_bits(PHASES)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load_valid,
   input  logic [LANES*PHASES-1:0] lane_words,
   output logic                    load_ready,
   output logic [LANES-1:0]        lane_bits,
   output logic                    fwd_clk,
   output logic [PW-1:0]           phase,
   output logic                    start_stb,
   output logic                    capture_stb
);

   // elaboration-time parameter checks
   if (PHASES < 2) begin : g_bad_phases
      $error("pix_serializer7: PHASES must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pix_serializer7: LANES must be at least 1");
   end
   if (START_PHASE >= PHASES) begin : g_bad_start
      $error("pix_serializer7: START_PHASE out of range");
   end
   if (CAPTURE_PHASE >= PHASES) begin : g_bad_capture
      $error("pix_serializer7: CAPTURE_PHASE out of range");
   end

   logic [PW-1:0] ph;
   logic [PW-1:0] ph_next;
   logic          wrap;

   pser_phase_ctr #(.PHASES(PHASES), .PW(PW)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .ph_next (ph_next),
      .wrap    (wrap)
   );

   assign phase      = ph;
   assign load_ready = wrap;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [PHASES-1:0] word_in;
      assign word_in = load_valid ? lane_words[g*PHASES +: PHASES] : '0;

      pser_lane_shift #(.WIDTH(PHASES)) u_shift (
         .clk       (clk),
         .rst       (rst),
         .load_en   (wrap),
         .load_word (word_in),
         .ser_o     (lane_bits[g])
      );
   end

   pser_fclk_gen #(.PHASES(PHASES), .PW(PW), .PATTERN(FCLK_PATTERN)) u_fclk (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .ph_next (ph_next),
      .fclk    (fwd_clk)
   );

   pser_strobe #(.PW(PW), .TARGET(START_PHASE)) u_start (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .ph_next (ph_next),
      .stb     (start_stb)
   );

   pser_strobe #(.PW(PW), .TARGET(CAPTURE_PHASE)) u_capture (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .ph_next (ph_next),
      .stb     (capture_stb)
   );

   // R2: ready lasts exactly one clock per period
   a_r2_ready_single_cycle: assert property (@(posedge clk) disable iff (rst)
      load_ready |=> !load_ready);

   // R8: an idle load edge leaves every lane silent in phase 0
   a_r8_idle_period_zero: assert property (@(posedge clk) disable iff (rst)
      (load_ready && !load_valid) |=> (lane_bits == '0));

   // R10: after a reset edge the block sits at phase zero with silent lanes
   a_r10_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (phase == '0 && lane_bits == '0 && fwd_clk == FCLK_PATTERN[0]));

endmodule

// File: tb/pix_serializer7_bench.sv
module pix_serializer7_bench;

   localparam int          LANES  = 4;
   localparam int          PH     = 7;
   localparam logic [6:0]  PAT    = 7'b1100011;
   localparam int          STARTP = 3;
   localparam int          CAPP   = 1;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                load_valid = 1'b0;
   logic [LANES*PH-1:0] lane_words = '0;
   logic                load_ready;
   logic [LANES-1:0]    lane_bits;
   logic                fwd_clk;
   logic [2:0]          phase;
   logic                start_stb;
   logic                capture_stb;

   always #2 clk = ~clk;

   pix_serializer7 u_pix_serializer7 (
      .clk         (clk),
      .rst         (rst),
      .load_valid  (load_valid),
      .lane_words  (lane_words),
      .load_ready  (load_ready),
      .lane_bits   (lane_bits),
      .fwd_clk     (fwd_clk),
      .phase       (phase),
      .start_stb   (start_stb),
      .capture_stb (capture_stb)
   );

   // behavioural reference: a phase integer and one held word per lane
   int         m_ph = 0;
   logic [6:0] m_word [LANES];
   initial for (int l = 0; l < LANES; l++) m_word[l] = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_ph = 0;
         for (int l = 0; l < LANES; l++) m_word[l] = '0;
      end else begin
         if (m_ph == PH - 1)
            for (int l = 0; l < LANES; l++)
               m_word[l] = load_valid ? lane_words[l*PH +: PH] : 7'd0;
         m_ph = (m_ph + 1) % PH;
      end
   end

   int    checks = 0;
   int    errors = 0;
   string tag    = "idle";
   bit    done   = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s] t=%0t: actual %0d expected %0d", req, tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R1 phase", phase, m_ph);
      check("R2 load_ready", load_ready, m_ph == PH - 1);
      for (int l = 0; l < LANES; l++)
         check("R3 R4 lane bit", lane_bits[l], m_word[l][PH - 1 - m_ph]);
      check("R5 fwd_clk", fwd_clk, PAT[m_ph]);
      check("R6 start_stb", start_stb, m_ph == STARTP);
      check("R7 capture_stb", capture_stb, m_ph == CAPP);
   endtask

   // mode 0: load every period; 1: stray valid and words off the load edge;
   // 2: mixed valid/idle load edges
   task automatic run(input int cycles, input int mode);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         compare_all();
         if (m_ph == PH - 1) begin
            lane_words = (LANES*PH)'({$urandom, $urandom});
            load_valid = (mode == 2) ? 1'($urandom) : 1'b1;
         end else begin
            if (mode == 1) begin
               lane_words = (LANES*PH)'({$urandom, $urandom});
               load_valid = 1'($urandom);
            end else begin
               load_valid = 1'b0;
            end
         end
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R10: state held under reset
      tag = "R10 reset";
      repeat (2) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         compare_all();
      end
      rst = 1'b0;

      tag = "normal load";
      run(70, 0);

      // R9: inputs toggled on non-ready clocks must not reach the lanes
      tag = "R9 stray valid";
      run(84, 1);

      // R8: some load edges without valid
      tag = "R8 idle period";
      run(63, 2);
      load_valid = 1'b0;
      run(14, 0);

      // R10: reset in the middle of a period (phase 4)
      tag = "R10 mid-period reset";
      while (m_ph != 4) begin
         @(negedge clk);
         compare_all();
      end
      rst = 1'b1;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         compare_all();
      end
      rst = 1'b0;
      run(28, 0);

      // R10: reset on a phase-6 edge with valid words offered
      tag = "R10 reset beats load";
      while (m_ph != PH - 1) begin
         @(negedge clk);
         compare_all();
      end
      lane_words = (LANES*PH)'({$urandom, $urandom});
      load_valid = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      compare_all();
      rst = 1'b0;
      load_valid = 1'b0;
      tag = "normal load";
      run(35, 0);

      done = 1;
      summary();
      $finish;
   end

endmodule